// File: doc/BRIEF.md
# Write-Only Two-Wire Command Receiver

This block is the receive side of a two-wire serial target that accepts only writes. The clock and data lines are sampled by a much faster system clock, and each line is cleaned by a synchronizer and a majority filter. The block finds START and STOP conditions on the cleaned lines and checks the first byte against a 7-bit target address. That address has a fixed upper nibble of `0101` and three strap inputs below it. The target then collects a command byte and a data byte, and acknowledges each accepted byte by pulling the data line low.

The collected bytes are held in the block until STOP. At STOP they are published together with a byte count as a one-cycle message strobe. Downstream logic reads the count to decide whether the message is complete (count 2) or partial and should be dropped. An address byte whose last bit is 1 is a no-operation request: it is neither acknowledged nor reported. A START that arrives before the STOP throws away everything collected since the previous START.

Top module: `i2c_wr_cmd_rx`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits, sent MSB first, equal `0101` followed by `strap_addr[2]`, `strap_addr[1]` and `strap_addr[0]`, and its eighth bit is 0. The acknowledge holds the line low through the high phase of the ninth clock.
- R2: An address byte whose eighth bit is 1 (no operation) with a matching address is not acknowledged. It produces no message, and the later bytes of that transfer are not acknowledged.
- R3: An address byte whose upper seven bits do not match is not acknowledged. `sda_oe` stays low for the whole of that transfer, and no message is produced.
- R4: After an acknowledged address, the first and second following bytes are acknowledged. Any byte after the second is not acknowledged and changes nothing.
- R5: START is a falling data line while the clock line is high, and STOP is a rising data line while the clock line is high. `msg_valid` rises for exactly one cycle after a STOP that ends an acknowledged write, and at no other time.
- R6: With the strobe, `msg_count` gives the number of bytes acknowledged after the address, capped at 2. A field that was not received reads 0.
- R7: Bytes are assembled MSB first. The first byte after the address appears on `msg_cmd` and the second on `msg_data`.
- R8: A START before STOP aborts the current transfer without producing a message, and address reception begins again.
- R9: A pulse one system-clock cycle long on either line has no effect on acknowledges or on the message.
- R10: After reset, `sda_oe`, `msg_valid`, `msg_count`, `msg_cmd` and `msg_data` are all 0.
- R11: `msg_cmd`, `msg_data` and `msg_count` keep their last published values until the next message is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as received |
| sda_in | input | 1 | Bus data line as received (wired level) |
| strap_addr | input | 3 | Low three bits of the target address |
| sda_oe | output | 1 | Pull the data line low (open drain) |
| msg_valid | output | 1 | One-cycle strobe: a message is published |
| msg_count | output | 2 | Bytes received after the address (0 to 2) |
| msg_cmd | output | 8 | First byte after the address |
| msg_data | output | 8 | Second byte after the address |

## Verification
A bit counter that is off by one would put the acknowledge one bus clock early or late, and the bench's acknowledge sample on the ninth clock of the first byte would catch it. A byte index or selection flag left set from an earlier transfer would show up at the very next STOP, as an extra or missing strobe or as a wrong count. Weak filtering would let the injected one-cycle pulses through as a false START or STOP, and a false START would silently drop the message that contained the pulse.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int BYTE_W   = 8;
  localparam int STRAP_W  = 3;
  localparam int CNT_W    = 2;
  localparam logic [3:0] DEV_PREFIX = 4'b0101;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_SHIFT,
    RX_ACK,
    RX_SKIP
  } rx_state_t;

  // true when the first byte addresses this target as a write
  function automatic logic addr_write_hit(input logic [BYTE_W-1:0] first_byte,
                                          input logic [STRAP_W-1:0] strap);
    return (first_byte[BYTE_W-1:1] == {DEV_PREFIX, strap}) && !first_byte[0];
  endfunction

  // ceiling of the count of received payload bytes
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur);
    return (cur == 2'd2) ? cur : cur + 2'd1;
  endfunction
endpackage

// File: rtl/i2cw_line_filter.sv
module i2cw_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int HALF = FILT_TAPS / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_TAPS-1:0]   win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      win_q  <= '1;
      clean  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      win_q  <= {win_q[FILT_TAPS-2:0], sync_q[SYNC_STAGES-1]};
      clean  <= ($countones(win_q) > HALF);
    end
  end
endmodule

// File: rtl/i2cw_bus_events.sv
module i2cw_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_c,
  input  logic sda_c,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_c;
      sda_p <= sda_c;
    end
  end

  assign ev_start = scl_c && scl_p && sda_p && !sda_c;
  assign ev_stop  = scl_c && scl_p && !sda_p && sda_c;
  assign ev_rise  = scl_c && !scl_p;
  assign ev_fall  = !scl_c && scl_p;

  // R5: the four bus events are mutually exclusive in any cycle
  assert_events_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_start, ev_stop, ev_rise, ev_fall}));
endmodule

// File: rtl/i2c_wr_cmd_rx.sv
module i2c_wr_cmd_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [2:0] strap_addr,
  output logic       sda_oe,
  output logic       msg_valid,
  output logic [1:0] msg_count,
  output logic [7:0] msg_cmd,
  output logic [7:0] msg_data
);
  import i2cw_pkg::*;

  localparam logic [3:0] BIT_FULL = 4'(BYTE_W);

  logic scl_c, sda_c;
  logic ev_start, ev_stop, ev_rise, ev_fall;

  i2cw_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_TAPS(FILT_TAPS)) u_scl_filt (
    .clk(clk), .rst_n(rst_n), .raw(scl_in), .clean(scl_c));
  i2cw_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_TAPS(FILT_TAPS)) u_sda_filt (
    .clk(clk), .rst_n(rst_n), .raw(sda_in), .clean(sda_c));

  i2cw_bus_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_c(scl_c), .sda_c(sda_c),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall));

  rx_state_t          state;
  logic [3:0]         bit_cnt;
  logic [1:0]         byte_idx;
  logic [CNT_W-1:0]   got_cnt;
  logic               sel;
  logic [BYTE_W-1:0]  shreg, cmd_q, data_q;

  // named internal events for the assertions
  logic byte_end, addr_hit;
  assign byte_end = (state == RX_SHIFT) && ev_fall && (bit_cnt == BIT_FULL);
  assign addr_hit = addr_write_hit(shreg, strap_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      bit_cnt   <= '0;
      byte_idx  <= '0;
      got_cnt   <= '0;
      sel       <= 1'b0;
      shreg     <= '0;
      cmd_q     <= '0;
      data_q    <= '0;
      sda_oe    <= 1'b0;
      msg_valid <= 1'b0;
      msg_count <= '0;
      msg_cmd   <= '0;
      msg_data  <= '0;
    end else begin
      msg_valid <= 1'b0;
      if (ev_start) begin
        state    <= RX_SHIFT;
        bit_cnt  <= '0;
        byte_idx <= '0;
        got_cnt  <= '0;
        sel      <= 1'b0;
        sda_oe   <= 1'b0;
        cmd_q    <= '0;
        data_q   <= '0;
      end else if (ev_stop) begin
        state  <= RX_IDLE;
        sda_oe <= 1'b0;
        sel    <= 1'b0;
        if (sel) begin
          msg_valid <= 1'b1;
          msg_count <= got_cnt;
          msg_cmd   <= cmd_q;
          msg_data  <= data_q;
        end
      end else begin
        case (state)
          RX_SHIFT: begin
            if (ev_rise && bit_cnt != BIT_FULL) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_c};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (byte_end) begin
              bit_cnt <= '0;
              case (byte_idx)
                2'd0: begin
                  if (addr_hit) begin
                    sel    <= 1'b1;
                    sda_oe <= 1'b1;
                    state  <= RX_ACK;
                  end else begin
                    state  <= RX_SKIP;
                  end
                end
                2'd1: begin
                  cmd_q   <= shreg;
                  got_cnt <= next_count(got_cnt);
                  sda_oe  <= 1'b1;
                  state   <= RX_ACK;
                end
                2'd2: begin
                  data_q  <= shreg;
                  got_cnt <= next_count(got_cnt);
                  sda_oe  <= 1'b1;
                  state   <= RX_ACK;
                end
                default: state <= RX_SKIP;
              endcase
            end
          end
          RX_ACK: begin
            if (ev_fall) begin
              sda_oe <= 1'b0;
              state  <= RX_SHIFT;
              if (byte_idx != 2'd3) byte_idx <= byte_idx + 2'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R5: the strobe only follows a detected STOP
  assert_pulse_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> $past(ev_stop));
  // R5: the strobe lasts a single cycle
  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> !msg_valid);
  // R1: acknowledge drive begins only right after a clock fall ending a byte
  assert_oe_starts_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(byte_end));
  // R8: any START or STOP releases the data line
  assert_oe_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start || ev_stop) |=> !sda_oe);
  // R3: the line is only pulled while this target is selected
  assert_oe_needs_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> sel);
  // R6: the published count never exceeds two
  assert_count_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_count <= 2'd2));
endmodule

// File: tb/i2c_wr_cmd_rx_tb_top.sv
module i2c_wr_cmd_rx_tb_top;
  localparam int Q = 20;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'd0;
  logic       sda_oe, msg_valid;
  logic [1:0] msg_count;
  logic [7:0] msg_cmd, msg_data;
  wire        sda_line = sda_m & ~sda_oe;

  i2c_wr_cmd_rx dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .strap_addr(strap), .sda_oe(sda_oe), .msg_valid(msg_valid),
    .msg_count(msg_count), .msg_cmd(msg_cmd), .msg_data(msg_data));

  int n_chk = 0, n_bad = 0, pulses = 0;
  bit oe_seen = 1'b0, done = 1'b0;
  logic [7:0] exp_cmd = 8'd0, exp_data = 8'd0;
  logic [1:0] exp_cnt = 2'd0;

  always @(negedge clk) begin
    if (rst_n && msg_valid) pulses++;
    if (rst_n && sda_oe) oe_seen = 1'b1;
  end

  task automatic chk_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit want_sel(input logic [6:0] a, input bit rw, input logic [2:0] s);
    return (a == {4'b0101, s}) && !rw;
  endfunction

  task automatic b_start;
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic b_stop;
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
  endtask

  // g: 1 = one-cycle low pulse on data while clock high, 2 = one-cycle clock pulse while low
  task automatic b_bit(input bit b, input int g);
    sda_m = b; wq(Q/2);
    if (g == 2) begin scl_m = 1'b1; wq(1); scl_m = 1'b0; end
    wq(Q/2); scl_m = 1'b1; wq(Q);
    if (g == 1) begin sda_m = 1'b0; wq(1); sda_m = 1'b1; end
    wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic b_byte(input logic [7:0] v, input int g, output bit ack);
    for (int i = 7; i >= 0; i--) b_bit(v[i], (i == 6) ? g : 0);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    ack = !sda_line;
    wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic txn(input logic [6:0] a, input bit rw, input int nb,
                     input logic [7:0] c, input logic [7:0] d, input logic [7:0] e,
                     input int g);
    bit ack, sel;
    int p0;
    string areq;
    sel = want_sel(a, rw, strap);
    areq = sel ? "R1 address ack" : (rw ? "R2 nop no ack" : "R3 mismatch no ack");
    p0 = pulses;
    oe_seen = 1'b0;
    b_start;
    b_byte({a, rw}, g, ack);
    chk_eq(areq, int'(ack), int'(sel));
    if (nb >= 1) begin b_byte(c, 0, ack); chk_eq("R4 command ack", int'(ack), int'(sel)); end
    if (nb >= 2) begin b_byte(d, 0, ack); chk_eq("R4 data ack", int'(ack), int'(sel)); end
    if (nb >= 3) begin b_byte(e, 0, ack); chk_eq("R4 extra byte nack", int'(ack), 0); end
    b_stop;
    wq(12);
    chk_eq("R5 strobe count", pulses - p0, int'(sel));
    if (!sel && (a != {4'b0101, strap})) chk_eq("R3 oe never driven", int'(oe_seen), 0);
    if (sel) begin
      exp_cnt  = (nb >= 2) ? 2'd2 : 2'(nb);
      exp_cmd  = (nb >= 1) ? c : 8'd0;
      exp_data = (nb >= 2) ? d : 8'd0;
    end
    chk_eq(sel ? "R6 count" : "R11 count held", int'(msg_count), int'(exp_cnt));
    chk_eq(sel ? "R7 command" : "R11 command held", int'(msg_cmd), int'(exp_cmd));
    chk_eq(sel ? "R7 data" : "R11 data held", int'(msg_data), int'(exp_data));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    int p0;
    void'($urandom(32'h5EED_0017));
    wq(5);
    chk_eq("R10 oe at reset", int'(sda_oe), 0);
    chk_eq("R10 strobe at reset", int'(msg_valid), 0);
    chk_eq("R10 count at reset", int'(msg_count), 0);
    chk_eq("R10 command at reset", int'(msg_cmd), 0);
    chk_eq("R10 data at reset", int'(msg_data), 0);
    rst_n = 1'b1;
    wq(10);

    strap = 3'b101;
    txn({4'b0101, 3'b101}, 1'b0, 2, 8'hC3, 8'h5A, 8'h00, 0);
    txn({4'b0101, 3'b101}, 1'b1, 2, 8'h11, 8'h22, 8'h00, 0);   // R2 nop
    txn({4'b0101, 3'b100}, 1'b0, 2, 8'h33, 8'h44, 8'h00, 0);   // R3 wrong strap
    txn({4'b1101, 3'b101}, 1'b0, 1, 8'h55, 8'h00, 8'h00, 0);   // R3 wrong prefix
    txn({4'b0101, 3'b101}, 1'b0, 0, 8'h00, 8'h00, 8'h00, 0);   // R6 count 0
    txn({4'b0101, 3'b101}, 1'b0, 1, 8'h80, 8'h00, 8'h00, 0);   // R6 count 1
    txn({4'b0101, 3'b101}, 1'b0, 3, 8'h01, 8'hFE, 8'h77, 0);   // R4 extra byte
    strap = 3'b000;
    txn({4'b0101, 3'b000}, 1'b0, 2, 8'hFF, 8'h00, 8'h00, 0);

    // R8: abort mid-byte with a repeated START
    p0 = pulses;
    b_start;
    b_byte({4'b0101, 3'b000, 1'b0}, 0, ack);
    b_byte(8'hA5, 0, ack);
    b_bit(1'b1, 0); b_bit(1'b0, 0); b_bit(1'b1, 0);
    txn({4'b0101, 3'b000}, 1'b0, 2, 8'h3C, 8'h96, 8'h00, 0);
    chk_eq("R8 single strobe after abort", pulses - p0, 1);

    // R9: one-cycle pulses on each line
    txn({4'b0101, 3'b000}, 1'b0, 2, 8'h6B, 8'hD2, 8'h00, 1);
    chk_eq("R9 data-line pulse ignored", int'(msg_cmd), 8'h6B);
    txn({4'b0101, 3'b000}, 1'b0, 2, 8'h29, 8'h4E, 8'h00, 2);
    chk_eq("R9 clock-line pulse ignored", int'(msg_data), 8'h4E);

    for (int k = 0; k < 30; k++) begin
      logic [6:0] a;
      bit rw;
      strap = 3'($urandom % 8);
      a = ($urandom % 2) ? {4'b0101, strap} : 7'($urandom);
      rw = (($urandom % 4) == 0);
      txn(a, rw, int'($urandom % 4), 8'($urandom), 8'($urandom), 8'($urandom), 0);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule